// File: doc/BRIEF.md
# Window Scaling DDA Address Stepper

This block turns output-pixel and output-line stepping of a display window into source-image coordinates, for horizontal and vertical scaling. A configuration load captures the source width and height, the output width and height, a fractional start phase for each axis and the pixel format. Two sequential dividers then work out one fixed-point increment per axis, with 12 fraction bits. When both are done, the block raises a ready flag and presents the two increments packed into one step word.

Once the block is ready, a scan engine pulses frame and line starts and advances by pixel and by line. Each axis keeps a fixed-point accumulator. Its integer part, the bits above the 12 fraction bits, is the source column or the source row for the current output position. From the captured format the block also reports whether low-depth pixels need colour expansion, and the line stride of the source in bytes. Fetching pixels, blending and interpolating are left to other blocks.

Top module: `dda_scaler_stepper`

## Requirements
- R1: Each axis increment equals (source size × 4096) divided by the clamped divisor, using integer division and truncating toward zero.
- R2: cfg_ready is low in the cycle after a cfg_load edge and rises exactly 24 clock edges after that load edge (NUM_W = DIM_W + FRAC_W). step_word is valid only while cfg_ready is high.
- R3: step_word carries the horizontal increment in bits [23:0] and the vertical increment in bits [47:24].
- R4: The divisor is output size minus 1, clamped to at least 1. An output size of 0 or 1 therefore gives an increment of source size × 4096.
- R5: The horizontal accumulator reloads its captured phase on line_start or frame_start. The vertical accumulator reloads on frame_start. A reload takes priority over an advance in the same cycle. The phase is a 12-bit fraction, so after a reload the coordinate is 0.
- R6: pix_adv adds the horizontal increment and line_adv adds the vertical increment. src_col and src_row are bits [24:12] of their 25-bit accumulators, which wrap modulo 2^25. The outputs update at the edge that samples the request.
- R7: While cfg_ready is low, frame_start, line_start, pix_adv and line_adv are ignored, and src_col and src_row hold.
- R8: color_expand is 1 when the captured format is 16 bpp (cfg_fmt32 = 0) and 0 when it is 32 bpp (cfg_fmt32 = 1), because expansion applies below 24 bpp.
- R9: line_stride equals the captured source width × 2 for 16 bpp, or × 4 for 32 bpp.
- R10: After reset, cfg_ready, step_word, src_col, src_row, line_stride and color_expand are all 0. The captured format resets to 32 bpp and both phases reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Capture the configuration and start both divisions |
| cfg_src_w | input | 12 | Source width in pixels |
| cfg_src_h | input | 12 | Source height in lines |
| cfg_out_w | input | 12 | Output width in pixels |
| cfg_out_h | input | 12 | Output height in lines |
| cfg_phase_h | input | 12 | Horizontal start phase (fraction) |
| cfg_phase_v | input | 12 | Vertical start phase (fraction) |
| cfg_fmt32 | input | 1 | 1 = 32 bpp, 0 = 16 bpp |
| frame_start | input | 1 | Reload both accumulators |
| line_start | input | 1 | Reload the horizontal accumulator |
| pix_adv | input | 1 | Advance one output pixel |
| line_adv | input | 1 | Advance one output line |
| cfg_ready | output | 1 | Increments valid, stepping enabled |
| step_word | output | 48 | Packed vertical/horizontal increments |
| color_expand | output | 1 | Low-depth format needs expansion |
| line_stride | output | 14 | Source line stride in bytes |
| src_col | output | 13 | Source column for the current pixel |
| src_row | output | 13 | Source row for the current line |

## Verification
A wrong quotient bit in a divider appears in step_word as soon as cfg_ready rises. It then spreads into every coordinate that follows, so one advance after a reload exposes it at src_col or src_row. A miscount in the divider's cycle counter shows up as cfg_ready rising one edge early or late. A bad reload priority or a missed gate on stepping changes src_col or src_row at the very next edge. The bench compares against its own arithmetic model after every pulse.

// File: rtl/dda_pkg.sv
package dda_pkg;

  typedef enum logic {
    PIX_16 = 1'b0,
    PIX_32 = 1'b1
  } pix_fmt_e;

  localparam int unsigned EXPAND_BELOW_BPP = 24;

  // Clamped DDA divisor: output size minus one, never below one.
  function automatic int unsigned div_denom(input int unsigned out_size);
    if (out_size <= 1) return 1;
    return out_size - 1;
  endfunction

  function automatic int unsigned bits_per_pixel(input pix_fmt_e f);
    return (f == PIX_32) ? 32 : 16;
  endfunction

  function automatic logic needs_expand(input pix_fmt_e f);
    return bits_per_pixel(f) < EXPAND_BELOW_BPP;
  endfunction

  function automatic int unsigned stride_bytes(input int unsigned w, input pix_fmt_e f);
    return (w * bits_per_pixel(f)) / 8;
  endfunction

endpackage

// File: rtl/dda_divider.sv
module dda_divider #(
  parameter int NUM_W = 24,
  parameter int DEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             busy,
  output logic [NUM_W-1:0] quo
);
  localparam int CNT_W  = $clog2(NUM_W + 1);
  localparam int WIDE_W = NUM_W + DEN_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [DEN_W:0]   rem;
  logic [NUM_W-1:0] q;
  logic [DEN_W-1:0] den_l;
  logic [NUM_W-1:0] num_l;
  logic [DEN_W:0]   trial;
  logic [DEN_W:0]   diff;
  logic             fits;

  // One restoring step per cycle, quotient bits shift in from the right.
  assign trial = {rem[DEN_W-1:0], q[NUM_W-1]};
  assign fits  = trial >= {1'b0, den_l};
  assign diff  = trial - {1'b0, den_l};
  assign busy  = (cnt != '0);
  assign quo   = q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      rem   <= '0;
      q     <= '0;
      den_l <= DEN_W'(1);
      num_l <= '0;
    end else if (start) begin
      cnt   <= CNT_W'(NUM_W);
      rem   <= '0;
      q     <= num;
      den_l <= den;
      num_l <= num;
    end else if (busy) begin
      cnt <= cnt - CNT_W'(1);
      rem <= fits ? diff : trial;
      q   <= {q[NUM_W-2:0], fits};
    end
  end

  assert_busy_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start) |=> (cnt == $past(cnt) - CNT_W'(1)));

  assert_div_exact_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (WIDE_W'(q) * WIDE_W'(den_l) + WIDE_W'(rem) == WIDE_W'(num_l)));

  assert_den_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (den_l != '0));

endmodule

// File: rtl/dda_axis.sv
module dda_axis #(
  parameter int COORD_W = 13,
  parameter int FRAC_W  = 12,
  parameter int INC_W   = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               reload,
  input  logic               adv,
  input  logic [FRAC_W-1:0]  phase,
  input  logic [INC_W-1:0]   inc,
  output logic [COORD_W-1:0] coord
);
  localparam int ACC_W = COORD_W + FRAC_W;

  logic [ACC_W-1:0] acc;
  logic             do_reload;
  logic             do_adv;

  assign do_reload = en && reload;
  assign do_adv    = en && adv && !reload;
  assign coord     = acc[ACC_W-1:FRAC_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         acc <= '0;
    else if (do_reload) acc <= ACC_W'(phase);
    else if (do_adv)    acc <= acc + ACC_W'(inc);
  end

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(coord));

  assert_reload_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && reload) |=> (coord == '0));

endmodule

// File: rtl/dda_fmt.sv
module dda_fmt #(
  parameter int DIM_W    = 12,
  parameter int STRIDE_W = 14
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic                fmt32,
  input  logic [DIM_W-1:0]    src_w,
  output logic                color_expand,
  output logic [STRIDE_W-1:0] stride
);
  import dda_pkg::*;

  pix_fmt_e         fmt_q;
  logic [DIM_W-1:0] w_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_q <= PIX_32;
      w_q   <= '0;
    end else if (load) begin
      fmt_q <= pix_fmt_e'(fmt32);
      w_q   <= src_w;
    end
  end

  assign color_expand = needs_expand(fmt_q);
  assign stride       = STRIDE_W'(stride_bytes(32'(w_q), fmt_q));

endmodule

// File: rtl/dda_scaler_stepper.sv
module dda_scaler_stepper #(
  parameter int DIM_W  = 12,
  parameter int FRAC_W = 12,
  localparam int NUM_W    = DIM_W + FRAC_W,
  localparam int INC_W    = NUM_W,
  localparam int COORD_W  = DIM_W + 1,
  localparam int STRIDE_W = DIM_W + 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_load,
  input  logic [DIM_W-1:0]    cfg_src_w,
  input  logic [DIM_W-1:0]    cfg_src_h,
  input  logic [DIM_W-1:0]    cfg_out_w,
  input  logic [DIM_W-1:0]    cfg_out_h,
  input  logic [FRAC_W-1:0]   cfg_phase_h,
  input  logic [FRAC_W-1:0]   cfg_phase_v,
  input  logic                cfg_fmt32,
  input  logic                frame_start,
  input  logic                line_start,
  input  logic                pix_adv,
  input  logic                line_adv,
  output logic                cfg_ready,
  output logic [2*INC_W-1:0]  step_word,
  output logic                color_expand,
  output logic [STRIDE_W-1:0] line_stride,
  output logic [COORD_W-1:0]  src_col,
  output logic [COORD_W-1:0]  src_row
);
  import dda_pkg::*;

  // Axis index 0 is horizontal, 1 is vertical.
  logic [1:0][DIM_W-1:0]   src_sz;
  logic [1:0][DIM_W-1:0]   out_sz;
  logic [1:0][FRAC_W-1:0]  phase_q;
  logic [1:0][INC_W-1:0]   quo;
  logic [1:0][COORD_W-1:0] coord;
  logic [1:0]              busy;
  logic [1:0]              reload;
  logic [1:0]              adv;
  logic                    valid_q;

  assign src_sz = {cfg_src_h, cfg_src_w};
  assign out_sz = {cfg_out_h, cfg_out_w};
  assign reload = {frame_start, line_start | frame_start};
  assign adv    = {line_adv, pix_adv};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      phase_q <= '0;
    end else if (cfg_load) begin
      valid_q <= 1'b1;
      phase_q <= {cfg_phase_v, cfg_phase_h};
    end
  end

  assign cfg_ready = valid_q && !(|busy);

  for (genvar g = 0; g < 2; g++) begin : g_axis
    logic [NUM_W-1:0] num;
    logic [DIM_W-1:0] den;

    assign num = {src_sz[g], FRAC_W'(0)};
    assign den = DIM_W'(div_denom(32'(out_sz[g])));

    dda_divider #(.NUM_W(NUM_W), .DEN_W(DIM_W)) u_div (
      .clk  (clk),
      .rst_n(rst_n),
      .start(cfg_load),
      .num  (num),
      .den  (den),
      .busy (busy[g]),
      .quo  (quo[g])
    );

    dda_axis #(.COORD_W(COORD_W), .FRAC_W(FRAC_W), .INC_W(INC_W)) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (cfg_ready),
      .reload(reload[g]),
      .adv   (adv[g]),
      .phase (phase_q[g]),
      .inc   (quo[g]),
      .coord (coord[g])
    );
  end

  assign step_word = quo;
  assign src_col   = coord[0];
  assign src_row   = coord[1];

  dda_fmt #(.DIM_W(DIM_W), .STRIDE_W(STRIDE_W)) u_fmt (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (cfg_load),
    .fmt32       (cfg_fmt32),
    .src_w       (cfg_src_w),
    .color_expand(color_expand),
    .stride      (line_stride)
  );

  assert_ready_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> !cfg_ready);

  assert_step_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_ready && !cfg_load) |=> $stable(step_word));

endmodule

// File: tb/dda_scaler_stepper_tb.sv
module dda_scaler_stepper_tb;
  localparam int NUM_W = 24;
  localparam longint ACC_MASK = (64'd1 << 25) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_load = 1'b0;
  logic [11:0] cfg_src_w = '0, cfg_src_h = '0, cfg_out_w = '0, cfg_out_h = '0;
  logic [11:0] cfg_phase_h = '0, cfg_phase_v = '0;
  logic        cfg_fmt32 = 1'b0;
  logic        frame_start = 1'b0, line_start = 1'b0, pix_adv = 1'b0, line_adv = 1'b0;
  logic        cfg_ready;
  logic [47:0] step_word;
  logic        color_expand;
  logic [13:0] line_stride;
  logic [12:0] src_col, src_row;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  longint acc_h = 0, acc_v = 0, inc_h = 0, inc_v = 0;

  always #2 clk = ~clk;

  dda_scaler_stepper u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
    .cfg_src_w(cfg_src_w), .cfg_src_h(cfg_src_h),
    .cfg_out_w(cfg_out_w), .cfg_out_h(cfg_out_h),
    .cfg_phase_h(cfg_phase_h), .cfg_phase_v(cfg_phase_v),
    .cfg_fmt32(cfg_fmt32), .frame_start(frame_start), .line_start(line_start),
    .pix_adv(pix_adv), .line_adv(line_adv), .cfg_ready(cfg_ready),
    .step_word(step_word), .color_expand(color_expand), .line_stride(line_stride),
    .src_col(src_col), .src_row(src_row)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint model_inc(input longint src, input longint outsz);
    longint d;
    d = (outsz < 2) ? 1 : outsz - 1;
    return (src * 4096) / d;
  endfunction

  task automatic do_load(input int sw, input int sh, input int ow, input int oh,
                         input int ph, input int pv, input bit f32);
    @(negedge clk);
    cfg_src_w = 12'(sw); cfg_src_h = 12'(sh); cfg_out_w = 12'(ow); cfg_out_h = 12'(oh);
    cfg_phase_h = 12'(ph); cfg_phase_v = 12'(pv); cfg_fmt32 = f32;
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    check("R2 ready low after load", longint'(cfg_ready), 0);
    for (int k = 1; k <= NUM_W; k++) begin
      @(negedge clk);
      if (k == NUM_W - 1) check("R2 ready not early", longint'(cfg_ready), 0);
      if (k == NUM_W) check("R2 ready on time", longint'(cfg_ready), 1);
    end
    inc_h = model_inc(sw, ow);
    inc_v = model_inc(sh, oh);
    check("R1 R3 horizontal increment", longint'(step_word[23:0]), inc_h);
    check("R1 R3 vertical increment", longint'(step_word[47:24]), inc_v);
    check("R8 color expand", longint'(color_expand), f32 ? 0 : 1);
    check("R9 line stride", longint'(line_stride), longint'(sw) * (f32 ? 4 : 2));
    acc_h = 0; acc_v = 0;
  endtask

  task automatic pulse(input bit fs, input bit ls, input bit pa, input bit la);
    frame_start = fs; line_start = ls; pix_adv = pa; line_adv = la;
    @(negedge clk);
    frame_start = 1'b0; line_start = 1'b0; pix_adv = 1'b0; line_adv = 1'b0;
    if (fs) begin acc_h = cfg_phase_h; acc_v = cfg_phase_v; end
    else begin
      if (ls) acc_h = cfg_phase_h;
      else if (pa) acc_h = (acc_h + inc_h) & ACC_MASK;
      if (la) acc_v = (acc_v + inc_v) & ACC_MASK;
    end
  endtask

  task automatic t_reset;
    check("R10 reset ready", longint'(cfg_ready), 0);
    check("R10 reset step word", longint'(step_word), 0);
    check("R10 reset col", longint'(src_col), 0);
    check("R10 reset row", longint'(src_row), 0);
    check("R10 reset stride", longint'(line_stride), 0);
    check("R10 reset expand", longint'(color_expand), 0);
  endtask

  task automatic t_upscale_walk;
    do_load(320, 240, 640, 480, 12'h800, 12'h400, 1'b0);
    pulse(1, 0, 0, 0);
    check("R5 frame start col", longint'(src_col), 0);
    check("R5 frame start row", longint'(src_row), 0);
    for (int i = 0; i < 20; i++) begin
      pulse(0, 0, 1, 0);
      check("R6 column after advance", longint'(src_col), acc_h >> 12);
    end
    for (int i = 0; i < 5; i++) begin
      pulse(0, 0, 0, 1);
      check("R6 row after line advance", longint'(src_row), acc_v >> 12);
    end
    pulse(0, 1, 0, 0);
    check("R5 line start reloads col", longint'(src_col), 0);
    check("R5 line start keeps row", longint'(src_row), acc_v >> 12);
    pulse(0, 0, 1, 1);
    check("R6 combined col", longint'(src_col), acc_h >> 12);
    check("R6 combined row", longint'(src_row), acc_v >> 12);
  endtask

  task automatic t_downscale;
    do_load(1920 % 4096, 1080, 800, 600, 0, 0, 1'b1);
    pulse(1, 0, 0, 0);
    for (int i = 0; i < 30; i++) begin
      pulse(0, 0, 1, (i % 3) == 0);
      check("R6 downscale col", longint'(src_col), acc_h >> 12);
      check("R6 downscale row", longint'(src_row), acc_v >> 12);
    end
  endtask

  task automatic t_priority;
    do_load(100, 50, 300, 200, 12'hfff, 12'h001, 1'b0);
    pulse(1, 0, 0, 0);
    pulse(0, 0, 1, 0);
    pulse(0, 0, 1, 0);
    pulse(0, 1, 1, 0);
    check("R5 reload beats advance", longint'(src_col), 0);
    pulse(0, 0, 1, 0);
    check("R5 phase restored then advanced", longint'(src_col), acc_h >> 12);
    pulse(0, 0, 1, 1);
    pulse(1, 0, 1, 1);
    check("R5 frame start beats advance col", longint'(src_col), 0);
    check("R5 frame start beats advance row", longint'(src_row), 0);
  endtask

  task automatic t_clamp;
    do_load(37, 2000, 1, 0, 0, 0, 1'b1);
    check("R4 width clamp", longint'(step_word[23:0]), 37 * 4096);
    check("R4 height clamp", longint'(step_word[47:24]), 2000 * 4096);
    do_load(9, 9, 2, 2, 0, 0, 1'b0);
    check("R4 size two divisor one", longint'(step_word[23:0]), 9 * 4096);
  endtask

  task automatic t_wrap;
    do_load(4095, 4095, 2, 3, 0, 0, 1'b1);
    pulse(1, 0, 0, 0);
    for (int i = 0; i < 4; i++) begin
      pulse(0, 0, 1, 1);
      check("R6 wrapping col", longint'(src_col), acc_h >> 12);
      check("R6 wrapping row", longint'(src_row), acc_v >> 12);
    end
  endtask

  task automatic t_ignore_busy;
    logic [12:0] c0, r0;
    do_load(200, 100, 50, 25, 0, 0, 1'b0);
    pulse(1, 0, 0, 0);
    for (int i = 0; i < 7; i++) pulse(0, 0, 1, 1);
    c0 = src_col; r0 = src_row;
    cfg_src_w = 12'd640; cfg_out_w = 12'd480;
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    for (int i = 0; i < 8; i++) begin
      pulse(i == 2, i == 4, 1, 1);
      check("R7 col held while busy", longint'(src_col), longint'(c0));
      check("R7 row held while busy", longint'(src_row), longint'(r0));
    end
    while (!cfg_ready) @(negedge clk);
    check("R7 col after ready", longint'(src_col), longint'(c0));
    check("R7 row after ready", longint'(src_row), longint'(r0));
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_upscale_walk();
    t_downscale();
    t_priority();
    t_clamp();
    t_wrap();
    t_ignore_busy();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule